// File: doc/BRIEF.md
# Two-Level Pending Interrupt Controller

This block gathers up to 32 interrupt request lines from peripherals and turns them into two request lines for a processor: a fast request and a normal request. Each request line is captured in a raw pending register on every clock edge at which it is high. This works for held levels and for one-cycle pulses, and it happens whether or not the source is enabled. A per-source enable mask and a per-source route bit then decide what the capture does. A routed-fast source drives the fast request directly. A routed-normal source competes for a single winner slot, which is a one-hot second-level pending register. The normal request is raised while that slot is occupied.

Software reaches the registers through a small synchronous register bus. Writes take effect on the clock edge. Reads are combinational from the address. A service routine reads the winner index from a read-only offset register. It then clears the raw pending bit and, after that, the winner bit, writing ones each time. Because of this order, the freed slot is refilled only from sources that are still pending.

Top module: `pend2_intc`

## Requirements
- R1: A high request line sets its bit in the raw pending register (address 0) at the next clock edge, whatever its mask and route bits hold.
- R2: Writing address 0 clears each raw pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R3: When a request line is high in the same cycle as a write-1 clear of its raw pending bit, the bit ends up set.
- R4: After reset the mask register (address 2) reads all ones, the raw pending, route (address 1) and winner (address 3) registers read zero, and both request outputs are low.
- R5: A source whose mask bit is 1 never enters the winner register. A mask bit of 0 allows service.
- R6: The winner register holds at most one set bit at any time.
- R7: While the winner register is empty, at each edge it loads the lowest-numbered raw pending source that is unmasked and has route bit 0. While it is occupied, it changes only through a write-1 clear.
- R8: irq_o is high exactly when the winner register holds a bit.
- R9: A route bit of 1 sends a source to the fast path. fiq_o is high whenever such a source is raw pending and unmasked, and that source never enters the winner register.
- R10: Writing 1s to address 3 clears winner bits. If the raw pending bit is cleared first, the same source is not chosen again.
- R11: Address 4 reads the index of the set winner bit, zero-extended, and reads 0 when the register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Request lines, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address (0 raw, 1 route, 2 mask, 3 winner, 4 offset) |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for bus_addr |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A request sampled at edge k appears in the raw pending register and on fiq_o after edge k. It reaches the winner register, irq_o and the offset read after edge k+1, and only if the slot was empty at that edge. Register writes take effect at the edge that samples them, and reads are combinational. The bench model updates on the same edge as the design. The bench drives and compares only on falling edges, so every result is checked half a cycle after the edge that produced it. Directed sequences check each of these points at its exact cycle, including the edge where the slot frees and refills from the next source.

// File: rtl/pend2_intc.sv
module pend2_intc #(
  parameter int N  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          fiq_o,
  output logic          irq_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] A_RAW  = AW'(0);
  localparam logic [AW-1:0] A_ROUTE = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_WIN  = AW'(3);
  localparam logic [AW-1:0] A_OFS  = AW'(4);

  logic [N-1:0]  src_q, mode_q, mask_q, int_q;
  logic [N-1:0]  cand, pick, clr_src, clr_int;
  logic [IW-1:0] ofs;

  assign clr_src = (bus_we && bus_addr == A_RAW) ? bus_wdata : '0;
  assign clr_int = (bus_we && bus_addr == A_WIN) ? bus_wdata : '0;

  // lowest set bit of the eligible normal-path sources
  assign cand = src_q & ~mask_q & ~mode_q;
  assign pick = cand & (~cand + N'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mode_q <= '0;
      mask_q <= '1;
      int_q  <= '0;
    end else begin
      src_q <= (src_q & ~clr_src) | req_i;
      if (bus_we && bus_addr == A_ROUTE) mode_q <= bus_wdata;
      if (bus_we && bus_addr == A_MASK)  mask_q <= bus_wdata;
      if (int_q == '0) int_q <= pick;
      else             int_q <= int_q & ~clr_int;
    end
  end

  always_comb begin
    ofs = '0;
    for (int i = 0; i < N; i++)
      if (int_q[i]) ofs = IW'(i);
  end

  always_comb begin
    case (bus_addr)
      A_RAW:   bus_rdata = src_q;
      A_ROUTE: bus_rdata = mode_q;
      A_MASK:  bus_rdata = mask_q;
      A_WIN:   bus_rdata = int_q;
      A_OFS:   bus_rdata = N'(ofs);
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = |int_q;
  assign fiq_o = |(src_q & ~mask_q & mode_q);
endmodule

// File: rtl/pend2_intc_chk.sv
module pend2_intc_chk #(
  parameter int N  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_i,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic          irq_o,
  input logic [N-1:0]  src_q,
  input logic [N-1:0]  mode_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  int_q
);
  a_r1_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((src_q & $past(req_i)) == $past(req_i)));

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_q));

  a_r5_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |=> ((int_q & $past(mask_q)) == '0));

  a_r9_fast_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |=> ((int_q & $past(mode_q)) == '0));

  a_r7_win_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |=> ((int_q & ~$past(src_q)) == '0));

  a_r10_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q != '0 && !(bus_we && bus_addr == AW'(3) && (bus_wdata & int_q) != '0))
      |=> (int_q == $past(int_q)));

  a_r8_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ($countones(int_q) == 1));
endmodule

bind pend2_intc pend2_intc_chk #(.N(N), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
  .src_q(src_q), .mode_q(mode_q), .mask_q(mask_q), .int_q(int_q)
);

// File: tb/pend2_intc_tb_top.sv
module pend2_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_src, m_mode, m_mask, m_int;

  always #5 clk = ~clk;

  pend2_intc dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_mode = 0; m_mask = 32'hFFFF_FFFF; m_int = 0;
    end else begin
      logic [31:0] nint;
      nint = m_int;
      if (m_int == 0) begin
        for (int i = 0; i < 32; i++)
          if (nint == 0 && m_src[i] && !m_mask[i] && !m_mode[i]) nint[i] = 1'b1;
      end else if (bus_we && bus_addr == 3) begin
        nint = m_int & ~bus_wdata;
      end
      if (bus_we && bus_addr == 0) m_src = m_src & ~bus_wdata;
      m_src = m_src | req_i;
      if (bus_we && bus_addr == 1) m_mode = bus_wdata;
      if (bus_we && bus_addr == 2) m_mask = bus_wdata;
      m_int = nint;
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    int idx;
    idx = 0;
    for (int i = 0; i < 32; i++) if (m_int[i]) idx = i;
    case (a)
      0: return m_src;
      1: return m_mode;
      2: return m_mask;
      3: return m_int;
      4: return idx;
      default: return 0;
    endcase
  endfunction

  function automatic logic model_fiq();
    return |(m_src & ~m_mask & m_mode);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  string rd_tag [5] = '{"R1", "R9", "R5", "R7", "R11"};

  // one cycle; compare all outputs against the model half a cycle after the edge
  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk(irq_o === (m_int != 0), "R8 irq_o", 32'(irq_o), 32'(m_int != 0));
      chk(fiq_o === model_fiq(), "R9 fiq_o", 32'(fiq_o), 32'(model_fiq()));
      #1;
      chk(bus_rdata === model_rd(bus_addr),
          (bus_addr < 5) ? rd_tag[bus_addr] : "R11", bus_rdata, model_rd(bus_addr));
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] r);
    req_i = r;
    step();
    req_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset values
    rd(3'd2, 32'hFFFF_FFFF, "R4 mask reset");
    rd(3'd0, 0, "R4 raw reset");
    rd(3'd1, 0, "R4 route reset");
    rd(3'd3, 0, "R4 winner reset");
    chk(irq_o === 0 && fiq_o === 0, "R4 outputs low", {30'd0, fiq_o, irq_o}, 0);
    rst_n = 1;
    step();

    // R1 and R5: masked source latches but never wins
    pulse(32'h20);
    rd(3'd0, 32'h20, "R1 masked latch");
    step();
    rd(3'd3, 0, "R5 masked no winner");
    chk(irq_o === 0, "R5 irq stays low", 32'(irq_o), 0);

    // R2: write 0 no effect, write 1 clears
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h20, "R2 write zero keeps");
    wr(3'd0, 32'h20);
    rd(3'd0, 0, "R2 write one clears");

    // R3: set beats clear
    req_i = 32'h80;
    wr(3'd0, 32'h80);
    req_i = 0;
    rd(3'd0, 32'h80, "R3 set wins");
    wr(3'd0, 32'h80);

    // R7 and R11: lowest index wins after one more edge
    wr(3'd2, 32'h0);
    pulse(32'h208);
    rd(3'd0, 32'h208, "R1 both latched");
    rd(3'd3, 0, "R7 not yet");
    step();
    rd(3'd3, 32'h8, "R7 lowest wins");
    rd(3'd4, 3, "R11 offset 3");
    chk(irq_o === 1, "R8 irq high", 32'(irq_o), 1);

    // R10: ordered clear, no re-win, next source fills
    wr(3'd0, 32'h8);
    rd(3'd3, 32'h8, "R10 winner held");
    wr(3'd3, 32'h8);
    rd(3'd3, 0, "R10 winner cleared");
    step();
    rd(3'd3, 32'h200, "R10 next source");
    rd(3'd4, 9, "R11 offset 9");
    wr(3'd0, 32'h200);
    wr(3'd3, 32'h200);
    step();
    rd(3'd3, 0, "R10 empty after service");
    rd(3'd4, 0, "R11 offset empty");

    // R9: fast routed source
    wr(3'd1, 32'h1000);
    pulse(32'h1000);
    chk(fiq_o === 1, "R9 fiq high", 32'(fiq_o), 1);
    step();
    rd(3'd3, 0, "R9 fast not in winner");
    wr(3'd2, 32'h1000);
    chk(fiq_o === 0, "R9 masked fast", 32'(fiq_o), 0);
    wr(3'd0, 32'h1000);
    wr(3'd2, 32'h0);

    // R5: masked bit 20 while others unmasked
    wr(3'd2, 32'h0010_0000);
    pulse(32'h0010_0000);
    step(); step();
    rd(3'd3, 0, "R5 masked bit 20");
    wr(3'd0, 32'hFFFF_FFFF);

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 0;
      req_i = r;
      case ($urandom % 8)
        0: begin bus_we = 1; bus_addr = 0; bus_wdata = $urandom; end
        1: begin bus_we = 1; bus_addr = 3; bus_wdata = $urandom; end
        2: begin bus_we = 1; bus_addr = ($urandom % 2) ? 3'd1 : 3'd2; bus_wdata = $urandom & $urandom; end
        default: begin bus_we = 0; bus_addr = 3'($urandom % 5); bus_wdata = 0; end
      endcase
      step();
    end
    req_i = 0; bus_we = 0;
    step();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule